// File: doc/BRIEF.md
# NAND Command and Address Write Path

This block sits between a simple host write port and the control pins of a NAND flash device. The host writes into one of two register windows: the command window or the address window. Each accepted write is queued in an eight-entry buffer. The buffer drains in arrival order onto the NAND bus. Each entry produces one or more device write cycles, with CLE raised for command writes and ALE raised for address writes. A 32-bit or 16-bit host write is cut into beats of the device width in little-endian order, so a driver can send several command or address bytes with one wide store.

The host acknowledges posted writes at once, so software can stream them until the buffer fills. A non-posted write holds the host until its last device cycle has finished. A configuration input forces every write to these windows to be treated as posted. Reads of the windows are acknowledged with zero, because written values are not kept. A status output tells software when the buffer has nothing left to send.

Top module: `nand_cmdaddr_wr`

## Requirements
- R1: Up to 8 writes may be pending. While 8 are pending, `hostReady` is low. It returns high once an entry has fully drained.
- R2: Entries drain strictly in the order they were accepted.
- R3: A non-posted write (`hostPosted`=0 with `forcePosted`=0) is acknowledged by a one-cycle `hostAck` pulse. The pulse appears in the cycle after its final device cycle completes, which is 1 + 4×beats clocks after acceptance into an idle block. `hostReady` stays low until then.
- R4: With `forcePosted`=1, a write marked non-posted is acknowledged one cycle after acceptance, and the next write can be accepted at once.
- R5: `bufEmpty` is high exactly when no entry is pending. It is high after reset and stays low until the last beat of the last entry has finished.
- R6: With an 8-bit device (`devWide`=0), `hostBe`=4'b1111 gives four beats, bytes 0,1,2,3 in that order. `hostBe`=4'b0011 or 4'b1100 gives two beats, the lower byte of the half first. Each beat carries its byte on `nandData[7:0]`, with `nandData[15:8]`=0.
- R7: With a 16-bit device (`devWide`=1), `hostBe`=4'b1111 gives two 16-bit beats, bits [15:0] first. `hostBe`=4'b0011 or 4'b1100 gives one 16-bit beat holding that half.
- R8: A one-hot `hostBe` (a single lane 0 to 3) gives exactly one beat, with that byte on `nandData[7:0]` and `nandData[15:8]`=0, for either device width. Any other strobe pattern is handled as a byte write of lane 0.
- R9: `hostWinSel`=0 selects the command window and raises `nandCle` on every beat. `hostWinSel`=1 selects the address window and raises `nandAle` on every beat.
- R10: A read (`hostWrite`=0) is acknowledged one cycle after acceptance with `hostRdata`=0. It produces no device cycle and leaves the buffer unchanged.
- R11: Each beat has three phases in order. First, one setup clock with the strobe high and CLE/ALE and data driven. Second, exactly two clocks with `nandWeN` low. Third, one hold clock with the strobe high and CLE/ALE still asserted. CLE, ALE and data are stable while the strobe is low.
- R12: A posted write is acknowledged by a `hostAck` pulse in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostValid | input | 1 | Host request valid |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostWinSel | input | 1 | Window select: 0 command, 1 address |
| hostWdata | input | 32 | Write data, byte lane n at bits [8n+7:8n] |
| hostBe | input | 4 | Byte lane strobes |
| hostPosted | input | 1 | Host marks write as posted |
| hostReady | output | 1 | Request accepted when high with hostValid |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read data, always zero |
| forcePosted | input | 1 | Treat all writes as posted |
| devWide | input | 1 | Device width: 0 = 8-bit, 1 = 16-bit |
| bufEmpty | output | 1 | High when no write is pending |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Active-low write strobe |
| nandData | output | 16 | Device data bus |

## Verification
The assertions check on every cycle that the buffer is never pushed when full or popped when empty. They also check that the strobe is low for exactly two clocks, that CLE/ALE lead the strobe by a setup clock and stay stable under it, and that the NAND pins are idle whenever the buffer reports empty. They further check that a non-posted acknowledge arrives only with the buffer empty. Beat contents, little-endian splitting for both device widths, the drain order, the full-buffer stall and the acknowledge timing of posted, forced-posted and non-posted writes can only be shown by the bench's scenarios. The bench compares every captured bus beat against values it computes from the strobes and data.

// File: rtl/nand_wr_pkg.sv
package nand_wr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef struct packed {
    logic        isAddr;
    accSize_e    size;
    logic [1:0]  offs;
    logic [31:0] data;
  } wrEntry_t;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic       active;
    logic [1:0] beatIdx;
  } seqCtl_t;

endpackage

// File: rtl/nand_wr_dpath.sv
module nand_wr_dpath
  import nand_wr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic             winSel,
  input  logic [31:0]      wdata,
  input  logic [3:0]       be,
  input  logic             devWide,
  output logic [CNT_W-1:0] count,
  output logic [2:0]       headBeats,
  output logic             nandCle,
  output logic             nandAle,
  output logic [15:0]      nandData
);

  wrEntry_t           mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  wrEntry_t           newEntry, head;
  logic [1:0]         loLane, hiLane;
  logic [15:0]        beatData;

  function automatic logic [7:0] laneByte(input logic [31:0] d, input logic [1:0] l);
    return d[8*l +: 8];
  endfunction

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // Strobe pattern to size and starting lane
  always_comb begin
    newEntry.isAddr = winSel;
    newEntry.data   = wdata;
    case (be)
      4'b1111: begin newEntry.size = SZ_WORD; newEntry.offs = 2'd0; end
      4'b0011: begin newEntry.size = SZ_HALF; newEntry.offs = 2'd0; end
      4'b1100: begin newEntry.size = SZ_HALF; newEntry.offs = 2'd2; end
      4'b0010: begin newEntry.size = SZ_BYTE; newEntry.offs = 2'd1; end
      4'b0100: begin newEntry.size = SZ_BYTE; newEntry.offs = 2'd2; end
      4'b1000: begin newEntry.size = SZ_BYTE; newEntry.offs = 2'd3; end
      default: begin newEntry.size = SZ_BYTE; newEntry.offs = 2'd0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop)  rdPtr <= nextPtr(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rdPtr];

  always_comb begin
    case (head.size)
      SZ_WORD: headBeats = devWide ? 3'd2 : 3'd4;
      SZ_HALF: headBeats = devWide ? 3'd1 : 3'd2;
      default: headBeats = 3'd1;
    endcase
  end

  // Little-endian split performed at drain time
  assign loLane = head.offs + (devWide ? {ctl.beatIdx[0], 1'b0} : ctl.beatIdx);
  assign hiLane = loLane + 2'd1;

  always_comb begin
    if (devWide && head.size != SZ_BYTE)
      beatData = {laneByte(head.data, hiLane), laneByte(head.data, loLane)};
    else
      beatData = {8'h00, laneByte(head.data, loLane)};
  end

  assign nandCle  = ctl.active && !head.isAddr;
  assign nandAle  = ctl.active && head.isAddr;
  assign nandData = ctl.active ? beatData : 16'h0000;

  a_r1_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> (count != CNT_W'(DEPTH)))
    else $error("push into full buffer");

  a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> (count != '0))
    else $error("pop from empty buffer");

endmodule

// File: rtl/nand_wr_ctrl.sv
module nand_wr_ctrl
  import nand_wr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostValid,
  input  logic             hostWrite,
  input  logic             hostPosted,
  input  logic             forcePosted,
  input  logic [CNT_W-1:0] count,
  input  logic [2:0]       headBeats,
  output logic             hostReady,
  output logic             hostAck,
  output logic             bufEmpty,
  output logic             nandWeN,
  output seqCtl_t          ctl
);

  logic       active;
  logic [1:0] phase;
  logic [1:0] beatIdx;
  logic       npPending;
  logic       accept, postedEff, doPush, doPop, lastBeat, lastEntry;

  assign postedEff = hostPosted || forcePosted;
  assign hostReady = (count != CNT_W'(DEPTH)) && !npPending;
  assign accept    = hostValid && hostReady;
  assign doPush    = accept && hostWrite;
  assign lastBeat  = ({1'b0, beatIdx} == (headBeats - 3'd1));
  assign lastEntry = (count == CNT_W'(1));
  assign doPop     = active && (phase == 2'd3) && lastBeat;
  assign bufEmpty  = (count == '0);
  assign nandWeN   = !(active && (phase == 2'd1 || phase == 2'd2));

  always_comb begin
    ctl.push    = doPush;
    ctl.pop     = doPop;
    ctl.active  = active;
    ctl.beatIdx = beatIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      phase     <= 2'd0;
      beatIdx   <= 2'd0;
      npPending <= 1'b0;
      hostAck   <= 1'b0;
    end else begin
      hostAck <= (accept && (!hostWrite || postedEff)) ||
                 (npPending && doPop && lastEntry);
      if (doPush && !postedEff)
        npPending <= 1'b1;
      else if (doPop && lastEntry)
        npPending <= 1'b0;
      if (!active) begin
        if (count != '0) begin
          active  <= 1'b1;
          phase   <= 2'd0;
          beatIdx <= 2'd0;
        end
      end else begin
        phase <= phase + 2'd1;
        if (phase == 2'd3) begin
          if (lastBeat) begin
            beatIdx <= 2'd0;
            active  <= !lastEntry || doPush;
          end else begin
            beatIdx <= beatIdx + 2'd1;
          end
        end
      end
    end
  end

  a_r11_strobe_two: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |=> !nandWeN)
    else $error("strobe shorter than two clocks");

  a_r11_strobe_end: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |=> nandWeN)
    else $error("strobe longer than two clocks");

  a_r3_np_ack_empty: assert property (@(posedge clk) disable iff (!rstN)
    (hostAck && $past(npPending)) |-> bufEmpty)
    else $error("non-posted ack before drain");

endmodule

// File: rtl/nand_cmdaddr_wr.sv
module nand_cmdaddr_wr
  import nand_wr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  input  logic        hostWrite,
  input  logic        hostWinSel,
  input  logic [31:0] hostWdata,
  input  logic [3:0]  hostBe,
  input  logic        hostPosted,
  output logic        hostReady,
  output logic        hostAck,
  output logic [31:0] hostRdata,
  input  logic        forcePosted,
  input  logic        devWide,
  output logic        bufEmpty,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic [15:0] nandData
);

  seqCtl_t          ctl;
  logic [CNT_W-1:0] count;
  logic [2:0]       headBeats;

  assign hostRdata = 32'h0;

  nand_wr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostPosted(hostPosted),
    .forcePosted(forcePosted), .count(count), .headBeats(headBeats),
    .hostReady(hostReady), .hostAck(hostAck), .bufEmpty(bufEmpty),
    .nandWeN(nandWeN), .ctl(ctl)
  );

  nand_wr_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .winSel(hostWinSel), .wdata(hostWdata), .be(hostBe), .devWide(devWide),
    .count(count), .headBeats(headBeats),
    .nandCle(nandCle), .nandAle(nandAle), .nandData(nandData)
  );

  a_r11_setup_lead: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |-> $past(nandCle || nandAle))
    else $error("no latch-enable setup before strobe");

  a_r11_stable_low: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> $stable({nandCle, nandAle, nandData}))
    else $error("bus changed under strobe");

  a_r5_idle_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty |-> (nandWeN && !nandCle && !nandAle))
    else $error("bus active while buffer empty");

endmodule

// File: tb/sim_nand_cmdaddr_wr.sv
`timescale 1ns/1ps
module sim_nand_cmdaddr_wr;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0, hostWrite = 1'b1, hostWinSel = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [3:0]  hostBe = '0;
  logic        hostPosted = 1'b1, forcePosted = 1'b0, devWide = 1'b0;
  logic        hostReady, hostAck, bufEmpty, nandCle, nandAle, nandWeN;
  logic [31:0] hostRdata;
  logic [15:0] nandData;

  int compared = 0, mismatched = 0, cyc = 0;

  nand_cmdaddr_wr u0 (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Beat log captured from the bus and expected beats computed here
  logic [17:0] logBeat [256];
  logic [17:0] expBeat [256];
  int logN = 0, expN = 0, cmpFrom = 0;

  logic       prevWeN = 1'b1;
  logic [1:0] prevSel = 2'b00, beatSel = 2'b00;
  logic [15:0] beatData = '0;
  int lowRun = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!nandWeN) begin
        if (prevWeN) begin
          chk(prevSel == {nandCle, nandAle} && prevSel != 2'b00, "R11", "setup lead",
              {30'h0, prevSel}, {30'h0, nandCle, nandAle});
          lowRun = 1;
          beatSel = {nandCle, nandAle};
          beatData = nandData;
        end else lowRun++;
      end else if (!prevWeN) begin
        chk(lowRun == 2, "R11", "strobe width", lowRun, 2);
        chk({nandCle, nandAle} == beatSel, "R11", "hold", {30'h0, nandCle, nandAle}, {30'h0, beatSel});
        logBeat[logN] = {beatSel, beatData};
        logN++;
      end
      prevWeN = nandWeN;
      prevSel = {nandCle, nandAle};
    end
  end

  function automatic logic [7:0] lb(input logic [31:0] d, input int l);
    return d[8*l +: 8];
  endfunction

  task automatic addExp(input logic win, input logic [3:0] be, input logic [31:0] d);
    logic [1:0] sel = win ? 2'b01 : 2'b10;
    int nset = $countones(be);
    if (nset == 1 || !(be == 4'b1111 || be == 4'b0011 || be == 4'b1100)) begin
      int ln = 0;
      for (int i = 3; i >= 0; i--) if (be[i] && nset == 1) ln = i;
      expBeat[expN++] = {sel, 8'h00, lb(d, ln)};
    end else if (!devWide) begin
      for (int i = 0; i < 4; i++)
        if (be[i]) expBeat[expN++] = {sel, 8'h00, lb(d, i)};
    end else begin
      for (int h = 0; h < 2; h++)
        if (be[2*h]) expBeat[expN++] = {sel, lb(d, 2*h+1), lb(d, 2*h)};
    end
  endtask

  task automatic doWrite(input logic wr, input logic win, input logic [3:0] be,
                         input logic [31:0] d, input logic posted,
                         output int acc, output logic ackNow);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostWinSel = win;
    hostBe = be; hostWdata = d; hostPosted = posted;
    while (!hostReady) @(negedge clk);
    @(posedge clk);
    acc = cyc;
    #1;
    hostValid = 1'b0;
    ackNow = hostAck;
    if (wr) addExp(win, be, d);
  endtask

  task automatic waitEmpty();
    while (!bufEmpty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compareLog(input string req);
    chk(logN == expN, req, "beat count", logN, expN);
    for (int i = cmpFrom; i < expN && i < logN; i++)
      chk(logBeat[i] == expBeat[i], req, $sformatf("beat %0d", i),
          {14'h0, logBeat[i]}, {14'h0, expBeat[i]});
    cmpFrom = expN;
  endtask

  logic [3:0] pats [7] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111};

  initial begin
    #400000;
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int acc, acc2, n;
    logic ak;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(bufEmpty == 1'b1, "R5", "empty after reset", bufEmpty, 1);
    chk(hostReady == 1'b1, "R1", "ready after reset", hostReady, 1);
    chk(nandWeN && !nandCle && !nandAle, "R11", "idle bus after reset",
        {nandWeN, nandCle, nandAle}, 3'b100);

    // Sweep all strobe patterns, both windows, both device widths
    for (int w = 0; w < 2; w++) begin
      devWide = w[0];
      for (int win = 0; win < 2; win++)
        for (int p = 0; p < 7; p++) begin
          logic [31:0] d = 32'h0;
          for (int b = 0; b < 4; b++) d[8*b +: 8] = 8'(16*(w*14 + win*7 + p) + 3*b + 1);
          doWrite(1'b1, win[0], pats[p], d, 1'b1, acc, ak);
          chk(ak == 1'b1, "R12", "posted ack", ak, 1);
          chk(bufEmpty == 1'b0, "R5", "not empty after write", bufEmpty, 0);
        end
      waitEmpty();
      compareLog(w == 0 ? "R6 R8 R9" : "R7 R8 R9");
    end

    // Fill the buffer: 8 pending words, then a ninth stalls
    devWide = 1'b0;
    for (int i = 0; i < 9; i++) begin
      doWrite(1'b1, i[0], 4'b1111, 32'h01020304 * (i + 1), 1'b1, acc, ak);
      if (i == 0) acc2 = acc;
      if (i == 7) chk(hostReady == 1'b0, "R1", "ready low when full", hostReady, 0);
      if (i == 8) chk(acc - acc2 > 9, "R1", "ninth write stalled", acc - acc2, 9);
    end
    waitEmpty();
    compareLog("R2");

    // Non-posted word, 8-bit device: ack after 1 + 4*4 clocks
    doWrite(1'b1, 1'b1, 4'b1111, 32'hDEADBEEF, 1'b0, acc, ak);
    chk(ak == 1'b0, "R3", "no early ack", ak, 0);
    chk(hostReady == 1'b0, "R3", "ready low while pending", hostReady, 0);
    n = 0;
    while (!hostAck && n < 100) begin
      chk(bufEmpty == 1'b0, "R5", "empty low during drain", bufEmpty, 0);
      @(posedge clk); #1; n++;
    end
    chk(n == 17, "R3", "ack latency", n, 17);
    chk(bufEmpty == 1'b1, "R5", "empty at ack", bufEmpty, 1);
    @(posedge clk); #1;
    chk(hostAck == 1'b0, "R3", "ack single pulse", hostAck, 0);
    waitEmpty();
    compareLog("R3");

    // Force posted: non-posted writes acknowledged at once
    forcePosted = 1'b1;
    doWrite(1'b1, 1'b0, 4'b0100, 32'h00AB0000, 1'b0, acc, ak);
    chk(ak == 1'b1, "R4", "forced posted ack", ak, 1);
    doWrite(1'b1, 1'b1, 4'b1100, 32'h55660000, 1'b0, acc2, ak);
    chk(acc2 - acc == 1, "R4", "next write accepted at once", acc2 - acc, 1);
    chk(ak == 1'b1, "R4", "second forced ack", ak, 1);
    forcePosted = 1'b0;
    waitEmpty();
    compareLog("R4 R6 R8");

    // Read: zero data, no device cycle
    n = logN;
    doWrite(1'b0, 1'b0, 4'b1111, 32'hFFFFFFFF, 1'b1, acc, ak);
    chk(ak == 1'b1, "R10", "read ack", ak, 1);
    chk(hostRdata == 32'h0, "R10", "read data", hostRdata, 0);
    chk(bufEmpty == 1'b1, "R10", "buffer untouched", bufEmpty, 1);
    repeat (30) @(negedge clk);
    chk(logN == n, "R10", "no device cycle", logN, n);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule